// File: doc/BRIEF.md
# Encoder Interrupt Status Controller

This block gathers the single-cycle event pulses of a quadrature encoder core and turns them into sticky flags in a 32-bit status word. Ten hardware sources feed it: index seen, velocity timer wrap, speed below threshold, direction reversal, phase fault, encoder clock tick, three position-compare hits and a revolution-compare hit. It also derives three compound flags. Each compound flag marks that one position-compare flag and the revolution flag have both been seen.

Software reaches the block through a small register port with three words. The status word is cleared by writing zeros. A write-one set word can force any flag. An enable mask selects which flags drive the single interrupt request line. The encoder datapaths are outside this block and appear here only as input pulses.

Top module: `enc_irq_status_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` (k = 0..9) sets status bit k at the next clock edge. The bit order is: index 0, timer wrap 1, slow speed 2, direction 3, phase fault 4, encoder clock 5, position-0 hit 6, position-1 hit 7, position-2 hit 8, revolution hit 9.
- R2: Bits 31..13 of every read value are zero. This holds for the status word and for the enable word alike.
- R3: A status flag stays set until software clears it.
- R4: A write to offset 0x0 clears each flag whose write-data bit is 0. It leaves unchanged each flag whose write-data bit is 1.
- R5: A write to offset 0x4 sets each flag whose write-data bit is 1. Bits written as 0 have no effect. Offset 0x4 reads as zero.
- R6: Compound flag n (status bit 10+n, n = 0..2) becomes set one cycle after status bits 6+n and 9 are both seen set.
- R7: A compound flag stays set after its constituent flags are cleared. It clears only when a 0 is written to its own bit.
- R8: After reset, all status flags, the enable word, the read data and the interrupt request are 0.
- R9: When a hardware event and a software clear of the same bit arrive in the same cycle, the flag ends up set.
- R10: The enable word is at offset 0x8. The interrupt request is high exactly when some status bit and its enable bit are both 1.
- R11: Read data is registered. It shows the word addressed in the previous cycle, and unknown offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 10 | Event pulses from the encoder core, bit k sets status bit k |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, OR of enabled status flags |

## Verification
The assertions check the following on every cycle:
- each flag latches its event, holds while no clear arrives, and drops after a clear that competes with no set;
- a set wins over a clear in the same cycle;
- compound flags follow their constituents one cycle later;
- reserved read bits stay zero;
- read data trails the address by one cycle.

Some behaviours only the bench scenarios can show:
- exact register contents after sequences of events and writes;
- compound flags that survive the clearing of their constituents;
- the set word reading zero;
- the interrupt line following the mask as it is reprogrammed.

// File: rtl/enc_irq_pkg.sv
package enc_irq_pkg;

  localparam int NUM_EVT  = 10;
  localparam int NUM_CMB  = 3;
  localparam int NUM_FLAG = NUM_EVT + NUM_CMB;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;

  localparam int POS_BASE = 6;
  localparam int REV_BIT  = 9;
  localparam int CMB_BASE = NUM_EVT;

  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(8);

  typedef logic [NUM_FLAG-1:0] flag_vec_t;

  // Compound-flag set pulses: position-n hit together with revolution hit.
  function automatic logic [NUM_CMB-1:0] cmb_hits(flag_vec_t f);
    logic [NUM_CMB-1:0] r;
    for (int n = 0; n < NUM_CMB; n++) r[n] = f[POS_BASE+n] & f[REV_BIT];
    return r;
  endfunction

  // Next value of one sticky flag; any set source beats a clear.
  function automatic logic next_flag(logic cur, logic clr, logic sset, logic hset);
    return (cur & ~clr) | sset | hset;
  endfunction

endpackage

// File: rtl/enc_irq_regport.sv
module enc_irq_regport
  import enc_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NF = NUM_FLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic [NF-1:0] stat_q,
  output logic [NF-1:0] clr_mask,
  output logic [NF-1:0] sw_set,
  output logic [NF-1:0] en_q,
  output logic [DW-1:0] bus_rdata
);

  localparam int PAD_W = DW - NF;
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_SET  = AW'(OFF_SET);
  localparam logic [AW-1:0] A_EN   = AW'(OFF_EN);

  logic wr_stat, wr_set, wr_en;
  logic unused_hi;

  assign wr_stat   = bus_we && (bus_addr == A_STAT);
  assign wr_set    = bus_we && (bus_addr == A_SET);
  assign wr_en     = bus_we && (bus_addr == A_EN);
  assign unused_hi = ^bus_wdata[DW-1:NF];

  assign clr_mask = wr_stat ? ~bus_wdata[NF-1:0] : '0;
  assign sw_set   = wr_set  ?  bus_wdata[NF-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) en_q <= bus_wdata[NF-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        A_STAT:  bus_rdata <= {{PAD_W{1'b0}}, stat_q};
        A_EN:    bus_rdata <= {{PAD_W{1'b0}}, en_q};
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NF] == '0); // R2

endmodule

// File: rtl/enc_irq_flag_bank.sv
module enc_irq_flag_bank
  import enc_irq_pkg::*;
#(
  parameter int NF = NUM_FLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] hw_set,
  input  logic [NF-1:0] sw_set,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] stat_q
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= next_flag(stat_q[i], clr_mask[i], sw_set[i], hw_set[i]);
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> stat_q[i]); // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_mask[i]) |=> stat_q[i]); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !hw_set[i] && !sw_set[i]) |=> !stat_q[i]); // R4
    AST_SW_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_set[i] |=> stat_q[i]); // R5
  end

endmodule

// File: rtl/enc_irq_combiner.sv
module enc_irq_combiner
  import enc_irq_pkg::*;
#(
  parameter int NF = NUM_FLAG,
  parameter int NC = NUM_CMB
) (
  input  logic [NF-1:0] stat_q,
  output logic [NC-1:0] cmb_set
);

  assign cmb_set = cmb_hits(stat_q);

endmodule

// File: rtl/enc_irq_status_ctrl.sv
module enc_irq_status_ctrl
  import enc_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [9:0]    evt_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);

  localparam int NF = NUM_FLAG;
  localparam int NC = NUM_CMB;

  logic [NF-1:0] stat_q, en_q, clr_mask, sw_set, hw_set;
  logic [NC-1:0] cmb_set;

  assign hw_set = {cmb_set, evt_i};
  assign irq_o  = |(stat_q & en_q);

  enc_irq_regport #(.DW(DW), .AW(AW), .NF(NF)) u_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .stat_q(stat_q), .clr_mask(clr_mask),
    .sw_set(sw_set), .en_q(en_q), .bus_rdata(bus_rdata)
  );

  enc_irq_flag_bank #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_set(sw_set),
    .clr_mask(clr_mask), .stat_q(stat_q)
  );

  enc_irq_combiner #(.NF(NF), .NC(NC)) u_cmb (
    .stat_q(stat_q), .cmb_set(cmb_set)
  );

  for (genvar n = 0; n < NC; n++) begin : g_cmb_chk
    AST_CMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[POS_BASE+n] && stat_q[REV_BIT]) |=> stat_q[CMB_BASE+n]); // R6
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R10

  AST_RDATA_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr == AW'(OFF_STAT)) |-> (bus_rdata[NF-1:0] == $past(stat_q))); // R11

endmodule

// File: tb/enc_irq_status_ctrl_bench.sv
module enc_irq_status_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  enc_irq_status_ctrl u_enc_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // vector: {op[1:0], data[31:0], exp_status[12:0], exp_irq}
  // op 0 event pulse, 1 write status, 2 write set, 3 write enable
  localparam int NV = 13;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 32'h0000_0001, 13'h0001, 1'b0},
    {2'd0, 32'h0000_0204, 13'h0205, 1'b0},
    {2'd3, 32'h0000_0004, 13'h0205, 1'b1},
    {2'd1, 32'hFFFF_FFFB, 13'h0201, 1'b0},
    {2'd0, 32'h0000_0040, 13'h0641, 1'b0},
    {2'd2, 32'h0000_0180, 13'h1FC1, 1'b0},
    {2'd1, 32'hFFFF_FC3F, 13'h1C01, 1'b0},
    {2'd3, 32'h0000_1000, 13'h1C01, 1'b1},
    {2'd1, 32'hFFFF_EFFF, 13'h0C01, 1'b0},
    {2'd2, 32'h0000_0000, 13'h0C01, 1'b0},
    {2'd0, 32'h0000_003A, 13'h0C3B, 1'b0},
    {2'd1, 32'hFFFF_FFFF, 13'h0C3B, 1'b0},
    {2'd1, 32'h0000_0000, 13'h0000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_evt(input logic [9:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 irq in reset", {31'b0, irq_o}, 32'h0);
    check("R8 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    do_read(4'h0, rd); check("R8 status after reset", rd, 32'h0);
    do_read(4'h8, rd); check("R8 enable after reset", rd, 32'h0);

    // Table walk: R1 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][47:46])
        2'd0: do_evt(VEC[v][23:14]);
        2'd1: do_write(4'h0, VEC[v][45:14]);
        2'd2: do_write(4'h4, VEC[v][45:14]);
        default: do_write(4'h8, VEC[v][45:14]);
      endcase
      @(negedge clk);
      do_read(4'h0, rd);
      check($sformatf("R1/R4/R7 vector %0d status", v), rd, {19'b0, VEC[v][13:1]});
      check($sformatf("R10 vector %0d irq", v), {31'b0, irq_o}, {31'b0, VEC[v][0]});
    end

    // R5 set word reads zero
    do_write(4'h4, 32'h0000_0002);
    do_read(4'h4, rd); check("R5 set word reads zero", rd, 32'h0);
    do_read(4'h0, rd); check("R5 set forces flag", rd, 32'h0000_0002);

    // R2 enable word upper bits read zero
    do_write(4'h8, 32'hFFFF_FFFF);
    do_read(4'h8, rd); check("R2 enable reserved bits", rd, 32'h0000_1FFF);
    // R11 registered read and unknown offset
    @(negedge clk); bus_addr = 4'h0;
    #1 check("R11 rdata before edge", bus_rdata, 32'h0000_1FFF);
    @(negedge clk); check("R11 rdata after edge", bus_rdata, 32'h0000_0002);
    do_read(4'hC, rd); check("R11 unknown offset", rd, 32'h0);

    // R6 timing of compound flag
    do_write(4'h0, 32'h0);
    do_write(4'h8, 32'h0000_0400);
    @(negedge clk); evt_i = 10'h240;
    @(negedge clk); evt_i = '0;
    check("R6 compound not yet set", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R6 compound set one cycle later", {31'b0, irq_o}, 32'h1);

    // R9 event beats clear in same cycle
    do_write(4'h0, 32'h0);
    do_write(4'h0, 32'h0);
    @(negedge clk); evt_i = 10'h010; bus_addr = 4'h0; bus_wdata = 32'h0; bus_we = 1'b1;
    @(negedge clk); evt_i = '0; bus_we = 1'b0;
    do_read(4'h0, rd); check("R9 event wins over clear", rd, 32'h0000_0010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule